// File: doc/BRIEF.md
# Prioritized CPU Interrupt Delivery Unit

This unit stands between the interrupt sources of a system and a processor core. It captures three kinds of request: a reset event, a non-maskable event, and a multi-bit maskable level. At each instruction boundary that the core signals, it picks at most one pending request and raises the matching exception request to the core for that single cycle. The reset and non-maskable requests share one combined exception line. The maskable level drives its own line.

The unit also owns the hardware-pending field of the core's cause register. Each time the maskable request is evaluated, it rewrites this field. A level of zero is not "idle": it is a distinct end-of-interrupt state, and serving it wipes the field. A maskable request that is blocked by the status enable bit or by the mask bits stays pending. It is tried again at every following boundary until it is delivered or replaced.

Top module: `irq_dispatch`

## Requirements
- R1: After a synchronous active-high `rst`, nothing is pending, `cause_ip_o` is 0 and neither request output is high at a boundary.
- R2: A `rst_evt_i` pulse is served at the next boundary as one `rstnmi_req_o` pulse, and the reset flag is then clear, so a later boundary gives no pulse.
- R3: A `nmi_evt_i` pulse is served at the next boundary as one `rstnmi_req_o` pulse, and the NMI flag is then clear.
- R4: With several requests pending, one is served per boundary: reset first, then NMI, then the level request; serving reset or NMI leaves `cause_ip_o` unchanged.
- R5: `rstnmi_req_o` and `irq_req_o` are high only in a cycle where `boundary_i` is high, and never both at once.
- R6: When a nonzero level is evaluated at a boundary, `cause_ip_o` takes the low IP_W bits of the level from the next cycle on.
- R7: `irq_req_o` pulses only if `stat_ie_i` is 1 and the low IP_W bits of the level ANDed with `stat_im_i` are nonzero; after a delivery the level request is no longer pending.
- R8: A nonzero level that is blocked stays pending, is evaluated again at each boundary, and is delivered at the first boundary where it is enabled and unmasked.
- R9: A `lvl_evt_i` with `lvl_i` = 0 records end-of-interrupt; the next boundary clears `cause_ip_o` to 0 and raises no request.
- R10: A new `lvl_evt_i` replaces any level request still pending, and the next boundary evaluates only the new value.
- R11: A reset or NMI event that arrives in the same cycle as a boundary is not served at that boundary; it stays latched and is served at a later boundary.
- R12: `cause_ip_o` changes only on the clock edge that ends a boundary cycle in which the level request was evaluated.
- R13: A nonzero level whose low IP_W bits are all zero gives `cause_ip_o` = 0 and is never delivered, but it stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_evt_i | input | 1 | Reset event strobe |
| nmi_evt_i | input | 1 | Non-maskable event strobe |
| lvl_evt_i | input | 1 | Strobe: `lvl_i` holds a new level |
| lvl_i | input | LVL_W (8) | Maskable level; 0 means end of interrupt |
| stat_ie_i | input | 1 | Status current-interrupt-enable bit |
| stat_im_i | input | IP_W (6) | Status interrupt-mask field, aligned with the IP field |
| boundary_i | input | 1 | Instruction-boundary strobe |
| rstnmi_req_o | output | 1 | Combined reset/NMI exception request pulse |
| irq_req_o | output | 1 | Maskable interrupt exception request pulse |
| cause_ip_o | output | IP_W (6) | Cause register hardware-pending field |

## Verification
A table of level values is applied against different pairs of enable bit and mask. The table separates four cases: a request that is enabled and matches the mask, one that misses the mask, one that is globally disabled, and one whose only set bits lie above the field. Each of these is followed by an end-of-interrupt, which must wipe the field. Directed sequences then load reset, NMI and level requests together to expose the serving order. They hold a blocked level across several boundaries and then enable it. They also place a new event in the same cycle as a delivery, which tells a latched request apart from one that is lost.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

    localparam int DEF_LVL_W = 8;
    localparam int DEF_IP_W  = 6;

    // State of the maskable level request
    typedef enum logic [1:0] {
        LV_IDLE = 2'd0,
        LV_EOI  = 2'd1,
        LV_ACT  = 2'd2
    } lvl_state_e;

    // Which request a boundary serves
    typedef enum logic [1:0] {
        SRV_NONE = 2'd0,
        SRV_RST  = 2'd1,
        SRV_NMI  = 2'd2,
        SRV_LVL  = 2'd3
    } serve_e;

    typedef struct packed {
        logic rst;
        logic nmi;
        logic lvl;
    } clr_t;

    function automatic serve_e pick_serve(input logic b, input logic p_rst,
                                          input logic p_nmi, input lvl_state_e st);
        serve_e s;
        s = SRV_NONE;
        if (b) begin
            if (p_rst)               s = SRV_RST;
            else if (p_nmi)          s = SRV_NMI;
            else if (st != LV_IDLE)  s = SRV_LVL;
        end
        return s;
    endfunction

endpackage

// File: rtl/irq_event_latch.sv
module irq_event_latch
    import irq_dispatch_pkg::*;
#(
    parameter int LVL_W = DEF_LVL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_evt,
    input  logic             nmi_evt,
    input  logic             lvl_evt,
    input  logic [LVL_W-1:0] lvl,
    input  clr_t             clr,
    output logic             pend_rst,
    output logic             pend_nmi,
    output lvl_state_e       lvl_state,
    output logic [LVL_W-1:0] lvl_val
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_rst <= 1'b0;
            pend_nmi <= 1'b0;
        end else begin
            pend_rst <= (pend_rst & ~clr.rst) | rst_evt;
            pend_nmi <= (pend_nmi & ~clr.nmi) | nmi_evt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_state <= LV_IDLE;
            lvl_val   <= '0;
        end else if (lvl_evt) begin
            lvl_state <= (lvl == '0) ? LV_EOI : LV_ACT;
            lvl_val   <= lvl;
        end else if (clr.lvl) begin
            lvl_state <= LV_IDLE;
        end
    end

    // R11
    evt_latched_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_evt |=> pend_rst) and (nmi_evt |=> pend_nmi));

    // R2
    rst_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        (clr.rst && !rst_evt) |=> !pend_rst);

    // R3
    nmi_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        (clr.nmi && !nmi_evt) |=> !pend_nmi);

    // R10
    lvl_replace_chk: assert property (@(posedge clk) disable iff (rst)
        lvl_evt |=> (lvl_val == $past(lvl)) && (lvl_state != LV_IDLE));

endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_dispatch_pkg::*;
#(
    parameter int LVL_W = DEF_LVL_W,
    parameter int IP_W  = DEF_IP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             boundary,
    input  logic             pend_rst,
    input  logic             pend_nmi,
    input  lvl_state_e       lvl_state,
    input  logic [LVL_W-1:0] lvl_val,
    input  logic             ie,
    input  logic [IP_W-1:0]  im,
    output logic             rstnmi_req,
    output logic             irq_req,
    output logic             cause_wr,
    output logic [IP_W-1:0]  cause_nxt,
    output clr_t             clr
);

    logic [IP_W-1:0] lvl_ip;
    serve_e          serve;
    logic            unmasked;

    // Fit the level onto the IP field width
    generate
        if (LVL_W >= IP_W) begin : g_trunc
            assign lvl_ip = lvl_val[IP_W-1:0];
        end else begin : g_pad
            assign lvl_ip = {{(IP_W-LVL_W){1'b0}}, lvl_val};
        end
    endgenerate

    always_comb begin
        serve      = pick_serve(boundary, pend_rst, pend_nmi, lvl_state);
        unmasked   = |(lvl_ip & im);
        rstnmi_req = (serve == SRV_RST) || (serve == SRV_NMI);
        irq_req    = (serve == SRV_LVL) && (lvl_state == LV_ACT) && ie && unmasked;
        cause_wr   = (serve == SRV_LVL);
        cause_nxt  = (lvl_state == LV_ACT) ? lvl_ip : '0;
        clr.rst    = (serve == SRV_RST);
        clr.nmi    = (serve == SRV_NMI);
        clr.lvl    = irq_req || ((serve == SRV_LVL) && (lvl_state == LV_EOI));
    end

    // R5
    pulse_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (rstnmi_req || irq_req) |-> boundary);

    // R5
    single_req_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rstnmi_req, irq_req}));

    // R7
    irq_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ie);

    // R4
    irq_after_nmi_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (!pend_rst && !pend_nmi));

endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
    import irq_dispatch_pkg::*;
#(
    parameter int IP_W = DEF_IP_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [IP_W-1:0] din,
    output logic [IP_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (wr) q <= din;
    end

    // R12
    cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(q));

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import irq_dispatch_pkg::*;
#(
    parameter int LVL_W = DEF_LVL_W,
    parameter int IP_W  = DEF_IP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_evt_i,
    input  logic             nmi_evt_i,
    input  logic             lvl_evt_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             stat_ie_i,
    input  logic [IP_W-1:0]  stat_im_i,
    input  logic             boundary_i,
    output logic             rstnmi_req_o,
    output logic             irq_req_o,
    output logic [IP_W-1:0]  cause_ip_o
);

    logic             pend_rst;
    logic             pend_nmi;
    lvl_state_e       lvl_state;
    logic [LVL_W-1:0] lvl_val;
    clr_t             clr;
    logic             cause_wr;
    logic [IP_W-1:0]  cause_nxt;

    irq_event_latch #(.LVL_W(LVL_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .rst_evt   (rst_evt_i),
        .nmi_evt   (nmi_evt_i),
        .lvl_evt   (lvl_evt_i),
        .lvl       (lvl_i),
        .clr       (clr),
        .pend_rst  (pend_rst),
        .pend_nmi  (pend_nmi),
        .lvl_state (lvl_state),
        .lvl_val   (lvl_val)
    );

    irq_select #(.LVL_W(LVL_W), .IP_W(IP_W)) u_select (
        .clk        (clk),
        .rst        (rst),
        .boundary   (boundary_i),
        .pend_rst   (pend_rst),
        .pend_nmi   (pend_nmi),
        .lvl_state  (lvl_state),
        .lvl_val    (lvl_val),
        .ie         (stat_ie_i),
        .im         (stat_im_i),
        .rstnmi_req (rstnmi_req_o),
        .irq_req    (irq_req_o),
        .cause_wr   (cause_wr),
        .cause_nxt  (cause_nxt),
        .clr        (clr)
    );

    irq_cause_reg #(.IP_W(IP_W)) u_cause (
        .clk (clk),
        .rst (rst),
        .wr  (cause_wr),
        .din (cause_nxt),
        .q   (cause_ip_o)
    );

    // R7
    irq_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req_o && !lvl_evt_i) |=> !irq_req_o);

endmodule

// File: tb/test_irq_dispatch.sv
module test_irq_dispatch;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rst_evt = 1'b0, nmi_evt = 1'b0, lvl_evt = 1'b0;
    logic [7:0] lvl = '0;
    logic       ie = 1'b0;
    logic [5:0] im = '0;
    logic       bnd = 1'b0;
    logic       rn, irq;
    logic [5:0] cause;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_dispatch i_irq_dispatch (
        .clk(clk), .rst(rst), .rst_evt_i(rst_evt), .nmi_evt_i(nmi_evt),
        .lvl_evt_i(lvl_evt), .lvl_i(lvl), .stat_ie_i(ie), .stat_im_i(im),
        .boundary_i(bnd), .rstnmi_req_o(rn), .irq_req_o(irq), .cause_ip_o(cause)
    );

    // Vector: {level[21:14], ie[13], im[12:7], exp_irq[6], exp_cause[5:0]}
    localparam logic [21:0] VEC [8] = '{
        {8'h05, 1'b1, 6'h01, 1'b1, 6'h05},
        {8'h05, 1'b1, 6'h02, 1'b0, 6'h05},
        {8'h05, 1'b0, 6'h3F, 1'b0, 6'h05},
        {8'h20, 1'b1, 6'h20, 1'b1, 6'h20},
        {8'h3F, 1'b1, 6'h00, 1'b0, 6'h3F},
        {8'hC3, 1'b1, 6'h02, 1'b1, 6'h03},
        {8'h40, 1'b1, 6'h3F, 1'b0, 6'h00},
        {8'h12, 1'b1, 6'h12, 1'b1, 6'h12}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Inputs are already set just after a negedge; check pulses 1 ns before the
    // posedge, then move to the next negedge and drop all strobes.
    task automatic tick(input bit do_chk, input logic e_rn, input logic e_irq,
                        input string tag);
        #4;
        if (do_chk) begin
            chk({tag, " rstnmi_req"}, rn, e_rn);
            chk({tag, " irq_req"}, irq, e_irq);
        end
        @(negedge clk);
        bnd = 1'b0; rst_evt = 1'b0; nmi_evt = 1'b0; lvl_evt = 1'b0;
    endtask

    task automatic set_lvl(input logic [7:0] v);
        lvl_evt = 1'b1; lvl = v;
        tick(1'b0, 1'b0, 1'b0, "");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 cause after reset", cause, 6'h00);
        bnd = 1'b1;
        tick(1'b1, 1'b0, 1'b0, "R1 boundary after reset");

        // Table: R6 R7 R13 then end-of-interrupt R9
        foreach (VEC[i]) begin
            ie = VEC[i][13]; im = VEC[i][12:7];
            set_lvl(VEC[i][21:14]);
            bnd = 1'b1;
            tick(1'b1, 1'b0, VEC[i][6], $sformatf("R7 vec%0d", i));
            chk($sformatf("R6 vec%0d cause", i), cause, VEC[i][5:0]);
            set_lvl(8'h00);
            bnd = 1'b1;
            tick(1'b1, 1'b0, 1'b0, $sformatf("R9 vec%0d eoi", i));
            chk($sformatf("R9 vec%0d cause", i), cause, 6'h00);
        end

        // R13 level above field stays pending and is never delivered
        ie = 1'b1; im = 6'h3F;
        set_lvl(8'h80);
        bnd = 1'b1; tick(1'b1, 1'b0, 1'b0, "R13 first boundary");
        bnd = 1'b1; tick(1'b1, 1'b0, 1'b0, "R13 second boundary");
        chk("R13 cause", cause, 6'h00);
        set_lvl(8'h00);
        bnd = 1'b1; tick(1'b1, 1'b0, 1'b0, "R9 eoi after R13");

        // R2 reset event served once
        rst_evt = 1'b1; tick(1'b1, 1'b0, 1'b0, "R5 event cycle no boundary");
        bnd = 1'b1; tick(1'b1, 1'b1, 1'b0, "R2 reset served");
        bnd = 1'b1; tick(1'b1, 1'b0, 1'b0, "R2 reset cleared");

        // R3 NMI served once
        nmi_evt = 1'b1; tick(1'b0, 1'b0, 1'b0, "");
        bnd = 1'b1; tick(1'b1, 1'b1, 1'b0, "R3 nmi served");
        bnd = 1'b1; tick(1'b1, 1'b0, 1'b0, "R3 nmi cleared");

        // R4 priority with all three pending; R12 cause untouched by reset/NMI
        ie = 1'b1; im = 6'h08;
        rst_evt = 1'b1; nmi_evt = 1'b1; lvl_evt = 1'b1; lvl = 8'h08;
        tick(1'b0, 1'b0, 1'b0, "");
        bnd = 1'b1; tick(1'b1, 1'b1, 1'b0, "R4 reset first");
        chk("R4 cause unchanged after reset", cause, 6'h00);
        bnd = 1'b1; tick(1'b1, 1'b1, 1'b0, "R4 nmi second");
        chk("R12 cause unchanged after nmi", cause, 6'h00);
        bnd = 1'b1; tick(1'b1, 1'b0, 1'b1, "R4 level third");
        chk("R4 cause after level", cause, 6'h08);

        // R8 blocked level retried until enabled
        ie = 1'b0; im = 6'h00;
        set_lvl(8'h04);
        bnd = 1'b1; tick(1'b1, 1'b0, 1'b0, "R8 blocked by ie");
        chk("R8 cause while blocked", cause, 6'h04);
        ie = 1'b1;
        bnd = 1'b1; tick(1'b1, 1'b0, 1'b0, "R8 blocked by mask");
        tick(1'b1, 1'b0, 1'b0, "R12 idle cycle");
        chk("R12 cause holds", cause, 6'h04);
        im = 6'h04;
        bnd = 1'b1; tick(1'b1, 1'b0, 1'b1, "R8 delivered once enabled");
        bnd = 1'b1; tick(1'b1, 1'b0, 1'b0, "R7 cleared after delivery");

        // R10 new level replaces blocked one
        im = 6'h02;
        set_lvl(8'h01);
        bnd = 1'b1; tick(1'b1, 1'b0, 1'b0, "R10 old level blocked");
        set_lvl(8'h02);
        chk("R12 cause before boundary", cause, 6'h01);
        bnd = 1'b1; tick(1'b1, 1'b0, 1'b1, "R10 new level delivered");
        chk("R10 cause", cause, 6'h02);

        // R11 reset event during an NMI delivery stays latched
        nmi_evt = 1'b1; tick(1'b0, 1'b0, 1'b0, "");
        bnd = 1'b1; rst_evt = 1'b1;
        tick(1'b1, 1'b1, 1'b0, "R11 nmi served with event");
        bnd = 1'b1; tick(1'b1, 1'b1, 1'b0, "R11 latched reset served");
        bnd = 1'b1; tick(1'b1, 1'b0, 1'b0, "R11 nothing left");

        // R11 level event during a level delivery stays pending
        im = 6'h03;
        set_lvl(8'h01);
        bnd = 1'b1; lvl_evt = 1'b1; lvl = 8'h02;
        tick(1'b1, 1'b0, 1'b1, "R11 level delivered with event");
        bnd = 1'b1; tick(1'b1, 1'b0, 1'b1, "R11 new level served");
        chk("R11 cause", cause, 6'h02);

        // R1 synchronous reset clears pending and cause
        nmi_evt = 1'b1; tick(1'b0, 1'b0, 1'b0, "");
        rst = 1'b1; tick(1'b0, 1'b0, 1'b0, "");
        rst = 1'b0;
        chk("R1 cause after mid reset", cause, 6'h00);
        bnd = 1'b1; tick(1'b1, 1'b0, 1'b0, "R1 nmi dropped by reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule